// File: doc/BRIEF.md
# Frame-Slip Elastic Store

This block buffers byte-serial line data between a receive side that runs on its own clock and frame sync and a time-division system side that runs on a second clock. Data is held as whole 32-byte frames. The write side stores each byte at the slot index it arrives with. A frame becomes available to the reader once its last slot has been written.

The read side asks for bytes by slot number. It decides which stored frame to play out only when it requests slot 0. If no new frame has arrived since the last one was read, the last frame is played out again (an underflow slip). If the writer has run so far ahead that the oldest unread frame is about to be overwritten, that frame is skipped (an overflow slip). No slip ever splits a frame. With filtering enabled, every byte of a repeated frame leaves with its valid flag low, so that downstream logic can discard the duplicate.

Two sticky flags, one for each kind of slip, report that a slip happened. Each is cleared by a one-cycle pulse on its clear input. The count of written frames crosses into the read clock domain as a Gray code through a two-flop synchronizer.

Top module: `ess_frame_store`

## Requirements
- R1: While `rst_n` is low and after its release, `rd_valid`, `slip_under` and `slip_over` are 0 until a read or a slip occurs.
- R2: A write (`wr_en` high) is stored only if `wr_fstart` is high with `wr_slot` = 0 in that cycle, or if a frame start has been seen since the last frame was completed. Writes before any frame start are dropped. A frame is completed when its slot 31 is written.
- R3: With `rd_en` high, the byte stored at slot `rd_slot` of the current read frame appears on `rd_byte` one `rclk` cycle later. All 32 slots are returned unchanged, including slot 0, which carries the framer status byte. The read frame is chosen only in a cycle with `rd_en` high and `rd_slot` = 0, and stays fixed for slots 1 to 31.
- R4: At a read frame start with between 1 and NFRM-2 completed unread frames, the oldest unread frame is played out. Frames are played out in write order.
- R5: At a read frame start with no completed unread frame, the frame played out last is played out again, and `slip_under` is set.
- R6: At a read frame start with NFRM-1 or more completed unread frames, the oldest unread frame is skipped, the next one is played out, and `slip_over` is set.
- R7: `rd_valid` is high one cycle after each `rd_en` cycle. The exception: when `filter_en` is 1, every byte of a repeated frame has `rd_valid` = 0. Bytes of a frame that is not repeated are always valid.
- R8: Each slip flag stays set until a one-cycle pulse on its clear input (`under_clr`, `over_clr`) in `rclk`. A slip in the same cycle as the clear pulse wins over the clear.
- R9: The written-frame count reaches the read domain as a Gray code, and the synchronized value changes by at most one bit per `rclk` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Receive-side (write) clock |
| rclk | input | 1 | System-side (read) clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| wr_en | input | 1 | Write strobe |
| wr_fstart | input | 1 | Marks slot 0 of an incoming frame |
| wr_slot | input | 5 | Slot index of the written byte |
| wr_byte | input | 8 | Written byte |
| rd_en | input | 1 | Read request |
| rd_slot | input | 5 | Slot index requested |
| filter_en | input | 1 | 1: bytes of repeated frames are marked invalid |
| under_clr | input | 1 | Clears `slip_under` (write-one) |
| over_clr | input | 1 | Clears `slip_over` (write-one) |
| rd_byte | output | 8 | Byte read, one cycle after the request |
| rd_valid | output | 1 | Valid flag for `rd_byte` |
| slip_under | output | 1 | Sticky: a frame was repeated |
| slip_over | output | 1 | Sticky: a frame was dropped |

## Verification
The assertions rely on three properties of the stimulus. Each side moves through slots 0 to 31 in ascending order. `wr_fstart` comes only with slot 0. The reader never falls more than NFRM frames behind the writer, so the unread-frame count cannot wrap. The bench writes and reads whole frames from separate tasks. Before a read frame starts, it waits long enough for the synchronizer to settle, so the unread count at each read frame start is known exactly. It paces writes so that the count stays between 0 and NFRM-1.

// File: rtl/ess_pkg.sv
package ess_pkg;
  localparam int SLOTS = 32;
  localparam int SW    = $clog2(SLOTS);

  function automatic logic [7:0] gray_to_bin8(input logic [7:0] g);
    logic [7:0] b;
    b[7] = g[7];
    for (int i = 6; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/ess_wr_side.sv
module ess_wr_side
  import ess_pkg::*;
#(
  parameter int PW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_fstart,
  input  logic [SW-1:0] wr_slot,
  output logic          wr_accept,
  output logic [PW-1:0] wptr,
  output logic [PW-1:0] wgray
);
  logic          in_frame_q, in_frame_d;
  logic [PW-1:0] wptr_q, wptr_d;
  logic [PW-1:0] wgray_q;
  logic          commit;

  always_comb begin
    wr_accept  = wr_en && ((wr_fstart && wr_slot == '0) || in_frame_q);
    commit     = wr_accept && (wr_slot == SW'(SLOTS - 1));
    wptr_d     = wptr_q + PW'(commit);
    in_frame_d = in_frame_q;
    if (wr_en && wr_fstart && wr_slot == '0) in_frame_d = 1'b1;
    else if (commit)                         in_frame_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame_q <= 1'b0;
      wptr_q     <= '0;
      wgray_q    <= '0;
    end else begin
      in_frame_q <= in_frame_d;
      wptr_q     <= wptr_d;
      wgray_q    <= wptr_d ^ (wptr_d >> 1);
    end
  end

  assign wptr  = wptr_q;
  assign wgray = wgray_q;

  // R2: frame count advances by one, and only after slot 31 is written
  p_frame_commit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wptr_q != $past(wptr_q)) |->
      (wptr_q == $past(wptr_q) + PW'(1)) && $past(wr_en && wr_slot == SW'(SLOTS - 1)));
endmodule

// File: rtl/ess_ptr_sync.sv
module ess_ptr_sync #(
  parameter int PW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] d,
  output logic [PW-1:0] q
);
  logic [PW-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;

  // R9: Gray-coded count changes at most one bit per read cycle
  p_gray_onebit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(s2_q ^ $past(s2_q)) <= 1);
endmodule

// File: rtl/ess_rd_side.sv
module ess_rd_side
  import ess_pkg::*;
#(
  parameter int NFRM = 4,
  parameter int PW   = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic [SW-1:0] rd_slot,
  input  logic          filter_en,
  input  logic [PW-1:0] wgray_sync,
  input  logic          under_clr,
  input  logic          over_clr,
  output logic [PW-2:0] frm_sel,
  output logic          rd_valid,
  output logic          slip_under,
  output logic          slip_over
);
  logic [PW-1:0] rptr_q, rptr_d, cur_frm_q, cur_frm_d, wbin, avail;
  logic          cur_rep_q, cur_rep_d, valid_q, valid_d;
  logic          under_q, under_d, over_q, over_d;
  logic          start, under_set, over_set, rep_now;

  always_comb begin
    wbin      = PW'(gray_to_bin8(8'(wgray_sync)));
    avail     = wbin - rptr_q;
    start     = rd_en && (rd_slot == '0);
    under_set = start && (avail == '0);
    over_set  = start && (avail >= PW'(NFRM - 1));
    rptr_d    = rptr_q;
    cur_frm_d = cur_frm_q;
    cur_rep_d = cur_rep_q;
    if (under_set) begin
      cur_frm_d = rptr_q - PW'(1);
      cur_rep_d = 1'b1;
    end else if (over_set) begin
      cur_frm_d = rptr_q + PW'(1);
      rptr_d    = rptr_q + PW'(2);
      cur_rep_d = 1'b0;
    end else if (start) begin
      cur_frm_d = rptr_q;
      rptr_d    = rptr_q + PW'(1);
      cur_rep_d = 1'b0;
    end
    rep_now = start ? cur_rep_d : cur_rep_q;
    frm_sel = start ? cur_frm_d[PW-2:0] : cur_frm_q[PW-2:0];
    valid_d = rd_en && !(rep_now && filter_en);
    under_d = under_set || (under_q && !under_clr);
    over_d  = over_set  || (over_q  && !over_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr_q    <= '0;
      cur_frm_q <= '0;
      cur_rep_q <= 1'b0;
      valid_q   <= 1'b0;
      under_q   <= 1'b0;
      over_q    <= 1'b0;
    end else begin
      rptr_q    <= rptr_d;
      cur_frm_q <= cur_frm_d;
      cur_rep_q <= cur_rep_d;
      valid_q   <= valid_d;
      under_q   <= under_d;
      over_q    <= over_d;
    end
  end

  assign rd_valid   = valid_q;
  assign slip_under = under_q;
  assign slip_over  = over_q;

  // R3: the read frame changes only at a slot-0 request
  p_frame_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && rd_slot == '0) |=> $stable(cur_frm_q) && $stable(cur_rep_q));
  // R5, R6: one frame start cannot be both kinds of slip
  p_one_slip_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(under_set && over_set));
  // R7: no valid byte without a request one cycle earlier
  p_valid_needs_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> $past(rd_en));
  // R8: flags hold until cleared
  p_sticky_under_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (under_q && !under_clr) |=> under_q);
  p_sticky_over_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (over_q && !over_clr) |=> over_q);
endmodule

// File: rtl/ess_frame_store.sv
module ess_frame_store
  import ess_pkg::*;
#(
  parameter int NFRM = 4,
  parameter int DW   = 8
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_fstart,
  input  logic [4:0]    wr_slot,
  input  logic [DW-1:0] wr_byte,
  input  logic          rd_en,
  input  logic [4:0]    rd_slot,
  input  logic          filter_en,
  input  logic          under_clr,
  input  logic          over_clr,
  output logic [DW-1:0] rd_byte,
  output logic          rd_valid,
  output logic          slip_under,
  output logic          slip_over
);
  localparam int FW    = $clog2(NFRM);
  localparam int PW    = FW + 1;
  localparam int DEPTH = NFRM * SLOTS;

  logic [1:0]    wrst_q, rrst_q;
  logic          wrst_n, rrst_n;
  logic          wr_accept;
  logic [PW-1:0] wptr, wgray, wgray_sync;
  logic [FW-1:0] frm_sel;
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rd_byte_q;

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) wrst_q <= '0;
    else        wrst_q <= {wrst_q[0], 1'b1};
  end
  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) rrst_q <= '0;
    else        rrst_q <= {rrst_q[0], 1'b1};
  end
  assign wrst_n = wrst_q[1];
  assign rrst_n = rrst_q[1];

  ess_wr_side #(.PW(PW)) u_wr (
    .clk(wclk), .rst_n(wrst_n), .wr_en(wr_en), .wr_fstart(wr_fstart),
    .wr_slot(wr_slot), .wr_accept(wr_accept), .wptr(wptr), .wgray(wgray)
  );

  ess_ptr_sync #(.PW(PW)) u_sync (
    .clk(rclk), .rst_n(rrst_n), .d(wgray), .q(wgray_sync)
  );

  ess_rd_side #(.NFRM(NFRM), .PW(PW)) u_rd (
    .clk(rclk), .rst_n(rrst_n), .rd_en(rd_en), .rd_slot(rd_slot),
    .filter_en(filter_en), .wgray_sync(wgray_sync), .under_clr(under_clr),
    .over_clr(over_clr), .frm_sel(frm_sel), .rd_valid(rd_valid),
    .slip_under(slip_under), .slip_over(slip_over)
  );

  always_ff @(posedge wclk) begin
    if (wr_accept) mem[{wptr[FW-1:0], wr_slot}] <= wr_byte;
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n)    rd_byte_q <= '0;
    else if (rd_en) rd_byte_q <= mem[{frm_sel, rd_slot}];
  end
  assign rd_byte = rd_byte_q;

  // R1: outputs idle right after reset release
  p_reset_idle_r1: assert property (@(posedge rclk) disable iff (!rrst_n)
    $rose(rrst_n) |-> !rd_valid && !slip_under && !slip_over);
endmodule

// File: tb/tb_ess_frame_store.sv
module tb_ess_frame_store;
  logic       wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
  logic       wr_en = 1'b0, wr_fstart = 1'b0, rd_en = 1'b0;
  logic [4:0] wr_slot = '0, rd_slot = '0;
  logic [7:0] wr_byte = '0, rd_byte;
  logic       filter_en = 1'b0, under_clr = 1'b0, over_clr = 1'b0;
  logic       rd_valid, slip_under, slip_over;
  int         checks = 0, errors = 0;
  bit         done = 1'b0;

  always #2.0 rclk = ~rclk;
  always #2.5 wclk = ~wclk;

  ess_frame_store dut (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wr_en(wr_en), .wr_fstart(wr_fstart),
    .wr_slot(wr_slot), .wr_byte(wr_byte), .rd_en(rd_en), .rd_slot(rd_slot),
    .filter_en(filter_en), .under_clr(under_clr), .over_clr(over_clr),
    .rd_byte(rd_byte), .rd_valid(rd_valid), .slip_under(slip_under), .slip_over(slip_over)
  );

  function automatic logic [7:0] pat(input int id, input int s);
    return {id[2:0], s[4:0]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_frame(input int id, input bit with_start);
    for (int s = 0; s < 32; s++) begin
      @(negedge wclk);
      wr_en = 1'b1; wr_slot = 5'(s); wr_byte = pat(id, s);
      wr_fstart = with_start && (s == 0);
    end
    @(negedge wclk);
    wr_en = 1'b0; wr_fstart = 1'b0;
  endtask

  task automatic read_frame(input string req, input int id, input bit exp_valid);
    for (int s = 0; s <= 32; s++) begin
      @(negedge rclk);
      if (s > 0) begin
        chk({req, " data"}, 32'(rd_byte), 32'(pat(id, s - 1)));
        chk({req, " valid"}, 32'(rd_valid), 32'(exp_valid));
      end
      if (s < 32) begin rd_en = 1'b1; rd_slot = 5'(s); end
      else rd_en = 1'b0;
    end
    @(negedge rclk);
    chk({req, " valid idle"}, 32'(rd_valid), 32'd0);
  endtask

  task automatic settle();
    repeat (12) @(negedge rclk);
  endtask

  task automatic pulse_clear(input bit u, input bit o);
    @(negedge rclk); under_clr = u; over_clr = o;
    @(negedge rclk); under_clr = 1'b0; over_clr = 1'b0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge rclk);
    chk("R1 valid", 32'(rd_valid), 0);
    chk("R1 under", 32'(slip_under), 0);
    chk("R1 over", 32'(slip_over), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge rclk);
    chk("R1 valid post", 32'(rd_valid), 0);
    chk("R1 flags post", 32'({slip_under, slip_over}), 0);
  endtask

  // R2 junk without frame start is dropped; R4/R9 frames arrive in order
  task automatic t_normal();
    write_frame(7, 1'b0);
    write_frame(1, 1'b1);
    write_frame(2, 1'b1);
    settle();
    read_frame("R2 R3 R4 R9 frame1", 1, 1'b1);
    read_frame("R4 frame2", 2, 1'b1);
    chk("R4 no slip", 32'({slip_under, slip_over}), 0);
  endtask

  task automatic t_underflow();
    read_frame("R5 R7 repeat unfiltered", 2, 1'b1);
    chk("R5 under set", 32'(slip_under), 1);
    chk("R5 over clear", 32'(slip_over), 0);
    repeat (5) @(negedge rclk);
    chk("R8 under sticky", 32'(slip_under), 1);
    pulse_clear(1'b1, 1'b0);
    chk("R8 under cleared", 32'(slip_under), 0);
    filter_en = 1'b1;
    read_frame("R7 repeat filtered", 2, 1'b0);
    chk("R5 under set again", 32'(slip_under), 1);
    pulse_clear(1'b1, 1'b0);
  endtask

  task automatic t_overflow();
    write_frame(3, 1'b1);
    write_frame(4, 1'b1);
    write_frame(5, 1'b1);
    settle();
    read_frame("R6 drop oldest", 4, 1'b1);
    chk("R6 over set", 32'(slip_over), 1);
    chk("R6 under clear", 32'(slip_under), 0);
    pulse_clear(1'b0, 1'b1);
    chk("R8 over cleared", 32'(slip_over), 0);
  endtask

  // R3 frame stays fixed while the writer commits mid-read; R7 filter on, fresh frame valid
  task automatic t_concurrent();
    fork
      write_frame(6, 1'b1);
      read_frame("R3 R7 fresh frame during write", 5, 1'b1);
    join
    settle();
    chk("R4 no slip after", 32'({slip_under, slip_over}), 0);
    read_frame("R4 next frame", 6, 1'b1);
  endtask

  initial begin
    t_reset();
    t_normal();
    t_underflow();
    t_overflow();
    t_concurrent();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge rclk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule